// File: doc/BRIEF.md
# Inter-Core Doorbell Mailbox Bank

This block holds sixteen 32-bit doorbell registers, four for each of four cores. Any bus master may post messages to a core by writing a word to one of the set-window addresses: every 1 bit of the word is ORed into the chosen mailbox, and no other bit changes. The core that owns the mailbox reads it and acknowledges messages by writing to the matching clear-window address. Every 1 bit of that word is removed from the mailbox. Each bit can stand for its own message code, so one mailbox carries up to 32 independent doorbells. Many senders can post without a read-modify-write sequence.

Each mailbox drives a flag that is high while its contents are nonzero. An interrupt router outside the block consumes these flags. The block performs one bus access per cycle. A write takes effect at the clock edge that samples it. Read data is registered.

Top module: `mbx_doorbell_bank`

## Requirements
- R1: Under the synchronous active-low reset, all mailboxes become zero. While and just after reset, `mbx_nonzero` and `bus_rdata` are zero.
- R2: A write to the set address of a mailbox ORs the 1 bits of `bus_wdata` into that mailbox. All other bits keep their value.
- R3: A write to the clear address of a mailbox clears the mailbox bits where `bus_wdata` is 1. All other bits keep their value.
- R4: A read of a clear address puts the mailbox contents on `bus_rdata` after the clock edge that samples the read.
- R5: A read of a set address also returns the mailbox contents, with the same timing as R4.
- R6: Bit `4n+m` of `mbx_nonzero` belongs to mailbox m of core n. It is 1 exactly when that mailbox holds a nonzero value, and it reflects a write from the edge that samples the write.
- R7: Addresses below 0x80 lie outside both windows. Writes there change no mailbox, and reads there return zero.
- R8: The set address of mailbox m of core n is 0x80 + 16n + 4m, and its clear address is 0xC0 + 16n + 4m. Address bits [1:0] are ignored.
- R9: An access to one mailbox leaves every other mailbox unchanged.
- R10: `bus_rdata` keeps its value on cycles that carry no read, including write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | An access is presented this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte address within the block |
| bus_wdata | input | 32 | Write data: the bit mask to set or clear |
| bus_rdata | output | 32 | Registered read data |
| mbx_nonzero | output | 16 | Per-mailbox nonzero flags, bit 4n+m for core n, mailbox m |

## Verification
The assertions assume that the bus presents at most one access per cycle. They also assume that `bus_valid`, `bus_write` and `bus_addr` hold stable, known values around each rising edge. The one-cycle relations between an access and its effect rest on these assumptions. The stimulus changes inputs only on falling edges and issues one access at a time. It returns `bus_valid` to 0 between groups of accesses, so each result is observed before the next access can disturb it.

// File: rtl/mbx_pkg.sv
// Package: shared sizes and the window type for the doorbell mailbox bank.
// Assumes word-aligned byte addresses with two low address bits ignored.
package mbx_pkg;
    localparam int DEF_CORES        = 4;
    localparam int DEF_MBX_PER_CORE = 4;
    localparam int DEF_DATA_W       = 32;

    // Which address window an access falls in.
    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_SET  = 2'd1,
        WIN_CLR  = 2'd2
    } win_e;
endpackage

// File: rtl/mbx_addr_decode.sv
// Module: mbx_addr_decode
// Splits an access into per-mailbox set and clear strobes plus a read
// request. The top two address bits pick the window (10 = set, 11 = clear).
// The following bits pick the mailbox, and bits [1:0] are ignored.
// Assumes at most one access per cycle.
module mbx_addr_decode
    import mbx_pkg::*;
#(
    parameter int NUM_MBX = 16,
    localparam int IDX_W  = $clog2(NUM_MBX),
    localparam int ADDR_W = IDX_W + 4
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [NUM_MBX-1:0] set_stb,
    output logic [NUM_MBX-1:0] clr_stb,
    output logic              rd_req,
    output logic              rd_in_win,
    output logic [IDX_W-1:0]  rd_idx
);
    win_e             win;
    logic [IDX_W-1:0] idx;
    logic [1:0]       unused_lsb;

    assign unused_lsb = acc_addr[1:0];
    assign idx        = acc_addr[IDX_W+1:2];

    // Classify the address into a window.
    always_comb begin
        unique case (acc_addr[ADDR_W-1 -: 2])
            2'b10:   win = WIN_SET;
            2'b11:   win = WIN_CLR;
            default: win = WIN_NONE;
        endcase
    end

    // One strobe pair per mailbox.
    for (genvar i = 0; i < NUM_MBX; i++) begin : g_stb
        assign set_stb[i] = acc_valid && acc_write && (win == WIN_SET)
                            && (idx == IDX_W'(i));
        assign clr_stb[i] = acc_valid && acc_write && (win == WIN_CLR)
                            && (idx == IDX_W'(i));
    end

    assign rd_req    = acc_valid && !acc_write;
    assign rd_in_win = (win != WIN_NONE);
    assign rd_idx    = idx;
endmodule

// File: rtl/mbx_cell.sv
// Module: mbx_cell
// One doorbell register with per-bit set and clear. If both strobes are
// active in one cycle, a bit that is both set and cleared stays set.
// Assumes a synchronous active-low reset.
module mbx_cell #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] value,
    output logic              nonzero
);
    logic [DATA_W-1:0] set_bits;
    logic [DATA_W-1:0] clr_bits;

    // Gate the write mask into set and clear bit vectors.
    always_comb begin
        set_bits = set_en ? mask : '0;
        clr_bits = clr_en ? mask : '0;
    end

    // Hold the mailbox; a set wins over a clear of the same bit.
    always_ff @(posedge clk) begin
        if (!rst_n) value <= '0;
        else        value <= (value & ~clr_bits) | set_bits;
    end

    assign nonzero = |value;
endmodule

// File: rtl/mbx_read_port.sv
// Module: mbx_read_port
// Registered read data. A read inside a window returns the selected
// mailbox, and a read outside returns zero. The data holds on other cycles.
// Assumes rd_idx is valid whenever rd_req and rd_in_win are high.
module mbx_read_port #(
    parameter int NUM_MBX = 16,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(NUM_MBX)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_req,
    input  logic                            rd_in_win,
    input  logic [IDX_W-1:0]                rd_idx,
    input  logic [NUM_MBX-1:0][DATA_W-1:0]  mbx_q,
    output logic [DATA_W-1:0]               rdata
);
    // Capture the selected mailbox on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_req) rdata <= rd_in_win ? mbx_q[rd_idx] : '0;
    end
endmodule

// File: rtl/mbx_doorbell_bank.sv
// Module: mbx_doorbell_bank (top)
// Doorbell mailbox bank for NUM_CORES cores with MBX_PER_CORE mailboxes each.
// Set window starts at 0x80, clear window at 0xC0 (for the default sizes).
// Mailbox index is core*MBX_PER_CORE + mailbox. Assumes one access per cycle.
module mbx_doorbell_bank
    import mbx_pkg::*;
#(
    parameter int NUM_CORES    = DEF_CORES,
    parameter int MBX_PER_CORE = DEF_MBX_PER_CORE,
    parameter int DATA_W       = DEF_DATA_W,
    localparam int NUM_MBX     = NUM_CORES * MBX_PER_CORE,
    localparam int IDX_W       = $clog2(NUM_MBX),
    localparam int ADDR_W      = IDX_W + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_MBX-1:0] mbx_nonzero
);
    logic [NUM_MBX-1:0]             set_stb;
    logic [NUM_MBX-1:0]             clr_stb;
    logic                           rd_req;
    logic                           rd_in_win;
    logic [IDX_W-1:0]               rd_idx;
    logic [NUM_MBX-1:0][DATA_W-1:0] mbx_q;

    mbx_addr_decode #(.NUM_MBX(NUM_MBX)) u_dec (
        .acc_valid (bus_valid),
        .acc_write (bus_write),
        .acc_addr  (bus_addr),
        .set_stb   (set_stb),
        .clr_stb   (clr_stb),
        .rd_req    (rd_req),
        .rd_in_win (rd_in_win),
        .rd_idx    (rd_idx)
    );

    // One register per mailbox.
    for (genvar i = 0; i < NUM_MBX; i++) begin : g_mbx
        mbx_cell #(.DATA_W(DATA_W)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_en  (set_stb[i]),
            .clr_en  (clr_stb[i]),
            .mask    (bus_wdata),
            .value   (mbx_q[i]),
            .nonzero (mbx_nonzero[i])
        );
    end

    mbx_read_port #(.NUM_MBX(NUM_MBX), .DATA_W(DATA_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .rd_in_win (rd_in_win),
        .rd_idx    (rd_idx),
        .mbx_q     (mbx_q),
        .rdata     (bus_rdata)
    );
endmodule

// File: rtl/mbx_doorbell_checker.sv
// Module: mbx_doorbell_checker
// Port-level properties of the doorbell bank, bound to the top module.
// Assumes one access per cycle and known inputs at each rising edge.
module mbx_doorbell_checker #(
    parameter int NUM_MBX  = 16,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_MBX),
    localparam int ADDR_W  = IDX_W + 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_MBX-1:0] mbx_nonzero
);
    // R1: outputs are clear when reset is released.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mbx_nonzero == '0 && bus_rdata == '0));

    // R2: a nonzero set write raises that mailbox's flag.
    a_r2_set_raises_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr[ADDR_W-1 -: 2] == 2'b10 && bus_wdata != '0)
        |=> mbx_nonzero[$past(bus_addr[IDX_W+1:2])]);

    // R3: clearing with all ones empties the mailbox.
    a_r3_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr[ADDR_W-1 -: 2] == 2'b11 && bus_wdata == '1)
        |=> !mbx_nonzero[$past(bus_addr[IDX_W+1:2])]);

    // R7: writes outside the windows leave every flag unchanged.
    a_r7_outside_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && !bus_addr[ADDR_W-1]) |=> $stable(mbx_nonzero));

    // R7: reads outside the windows return zero.
    a_r7_outside_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && !bus_addr[ADDR_W-1]) |=> (bus_rdata == '0));

    // R10: read data holds when no read is presented.
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));
endmodule

bind mbx_doorbell_bank mbx_doorbell_checker #(.NUM_MBX(NUM_MBX), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .mbx_nonzero (mbx_nonzero)
);

// File: tb/tb_mbx_doorbell_bank.sv
module tb_mbx_doorbell_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] mbx_nonzero;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] model [16];
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        cmp_next = 1'b0;
    logic [31:0] last_rd = '0;

    always #4 clk = ~clk; // 125 MHz

    mbx_doorbell_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mbx_nonzero(mbx_nonzero)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] nz_expect();
        logic [15:0] v;
        for (int i = 0; i < 16; i++) v[i] = (model[i] != 0);
        return v;
    endfunction

    // Driver: one write, model updated per the requirements.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        if (a >= 8'h80 && a < 8'hC0) model[(a - 8'h80) >> 2] |= d;
        else if (a >= 8'hC0)         model[(a - 8'hC0) >> 2] &= ~d;
    endtask

    // Driver: one read, expected value pushed to the scoreboard.
    task automatic rd(input logic [7:0] a, input string req);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_wdata = '0;
        if (a >= 8'h80 && a < 8'hC0)  exp_q.push_back(model[(a - 8'h80) >> 2]);
        else if (a >= 8'hC0)          exp_q.push_back(model[(a - 8'hC0) >> 2]);
        else                          exp_q.push_back(32'h0);
        tag_q.push_back(req);
    endtask

    task automatic idle();
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    // Monitor: flag reads sampled at this edge, compare on the next falling edge.
    always @(posedge clk) cmp_next <= rst_n && bus_valid && !bus_write;

    always @(negedge clk) begin
        if (cmp_next && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            last_rd = e;
            check(t, bus_rdata, e);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        check("R1 nonzero in reset", {16'h0, mbx_nonzero}, 32'h0);
        check("R1 rdata in reset", bus_rdata, 32'h0);
        rst_n = 1'b1;

        // R2, R4, R6: accumulate bits in core 0 mailbox 0.
        wr(8'h80, 32'h0000_0001);
        wr(8'h80, 32'h0000_0100);
        idle();
        check("R6 flag after set", {16'h0, mbx_nonzero}, {16'h0, nz_expect()});
        rd(8'hC0, "R4 read clear window");
        rd(8'h80, "R5 read set window");
        idle();

        // R3: clear one bit only.
        wr(8'hC0, 32'h0000_0001);
        rd(8'hC0, "R3 partial clear");
        idle();

        // R8, R9: core 2 mailbox 3, then neighbours.
        wr(8'hAC, 32'hDEAD_BEEF);
        idle();
        check("R6 R9 flags core2 mbx3", {16'h0, mbx_nonzero}, {16'h0, nz_expect()});
        rd(8'hEC, "R8 core2 mbx3 clear addr");
        rd(8'hE8, "R9 neighbour untouched");
        wr(8'hAD, 32'h0000_0010);
        rd(8'hAF, "R8 low bits ignored");
        idle();

        // R7: outside the windows.
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h7C, 32'hFFFF_FFFF);
        idle();
        check("R7 flags after outside write", {16'h0, mbx_nonzero}, {16'h0, nz_expect()});
        rd(8'h44, "R7 outside read zero");
        rd(8'hAC, "R7 mailbox untouched");
        idle();

        // R10: read data holds across a write and idle cycles.
        wr(8'h84, 32'h0000_0F00);
        idle(); idle();
        check("R10 rdata held", bus_rdata, last_rd);

        // R3: full clear empties and drops the flag.
        wr(8'hEC, 32'hFFFF_FFFF);
        idle();
        check("R3 flag after full clear", {16'h0, mbx_nonzero}, {16'h0, nz_expect()});

        // R8, R9: every mailbox gets a distinct pattern.
        for (int i = 0; i < 16; i++) wr(8'h80 + 8'(4 * i), 32'h1 << (i + 8) | 32'(i));
        idle();
        check("R6 all flags", {16'h0, mbx_nonzero}, {16'h0, nz_expect()});
        for (int i = 0; i < 16; i++) rd(8'hC0 + 8'(4 * i), "R8 sweep clear window");
        for (int i = 0; i < 16; i++) rd(8'h80 + 8'(4 * i), "R5 sweep set window");
        idle();
        for (int i = 0; i < 16; i += 2) wr(8'hC0 + 8'(4 * i), 32'hFFFF_FFFF);
        idle();
        check("R9 alternate clears", {16'h0, mbx_nonzero}, {16'h0, nz_expect()});

        // R1: reset in the middle of activity.
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 16; i++) model[i] = '0;
        @(negedge clk); @(negedge clk);
        check("R1 flags after mid reset", {16'h0, mbx_nonzero}, 32'h0);
        check("R1 rdata after mid reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        rd(8'h9C, "R1 mailbox cleared");
        idle(); idle();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule